// File: doc/BRIEF.md
# DMA Minor/Major Loop Controller

This block steps one DMA channel through its transfer loops. A service request comes from a hardware request level or a software start pulse. Each request runs one minor loop: the block asks for read/write beats on `beat_req`, and each acknowledged beat moves `BEAT_BYTES` bytes until the programmed byte count is used up. At the end of each minor loop the current iteration count drops by one. When that count reaches zero the major loop is complete. The count is then reloaded from the begin count, the completion flag is set, and the completion events are issued.

Events are single-cycle pulses. A request to a linked channel can fire after every minor loop or only at major completion. Interrupt requests can fire at completion and at the half-way count. A pulse can also tell the surrounding logic to withdraw the channel's hardware request enable. A programmable stall between beats limits bus bandwidth. In continuous link mode, a minor link that points back at the channel itself restarts the next minor loop at once, with no new request. Address generation and arbitration are handled elsewhere.

All completion events appear in the clock cycle after the edge that samples the last `beat_done` of a minor loop.

Top module: `dma_loop_ctrl`

## Requirements
- R1: After an accepted start, `beat_req` stays high until `beat_done` has been seen `cfg_nbytes / BEAT_BYTES` times. It then drops, unless R9 applies. A `beat_done` that arrives while `beat_req` is low is ignored.
- R2: The first start of a major loop loads `citer` from `cfg_biter`. Each minor loop end lowers `citer` by one. When it would reach zero, `citer` is reloaded with `cfg_biter` and `done` is set.
- R3: `cfg_bwc` sets the gap between beats inside a minor loop: code 2 holds `beat_req` low for 4 cycles, code 3 holds it low for 8 cycles, and codes 0 and 1 give no gap.
- R4: `cfg_link_mode` 1 (minor) pulses `link_req` for one cycle at every minor loop end. Mode 2 (major) pulses it only at major completion. Modes 0 and 3 never pulse it. `link_ch` carries `cfg_link_ch` during the pulse.
- R5: With `cfg_int_major` set, `int_major` pulses for one cycle at major completion.
- R6: With `cfg_int_half` set and `cfg_biter >= 2`, `int_half` pulses for one cycle at the minor loop end where the new count equals `cfg_biter >> 1`.
- R7: With `cfg_auto_stop` set, `req_off` pulses for one cycle at major completion.
- R8: A start is refused, and `cfg_err` pulses for one cycle, when `cfg_nbytes` is zero, when `cfg_nbytes` is not a multiple of `BEAT_BYTES`, or when a major loop would begin with `cfg_biter` zero. A refused start does not begin any beats.
- R9: With `cfg_contlink` set, link mode 1 and `cfg_link_ch == cfg_self_ch`, a minor loop end that is not a major completion starts the next minor loop in the following cycle. No `link_req` is issued in that case.
- R10: `done` stays set until `done_clr` is pulsed. A set in the same cycle as a clear wins.
- R11: `hw_req` and `sw_start` start a minor loop in the same way. Either one is ignored while a minor loop is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_req | input | 1 | Hardware service request |
| sw_start | input | 1 | Software start pulse |
| beat_done | input | 1 | Current read/write beat finished |
| done_clr | input | 1 | Clears the completion flag |
| cfg_nbytes | input | NB_W | Bytes per minor loop |
| cfg_biter | input | IT_W | Begin iteration count |
| cfg_bwc | input | 2 | Bandwidth stall code |
| cfg_link_mode | input | 2 | 0 none, 1 minor, 2 major, 3 none |
| cfg_link_ch | input | CH_W | Channel to link to |
| cfg_self_ch | input | CH_W | This channel's number |
| cfg_contlink | input | 1 | Continuous link mode enable |
| cfg_int_major | input | 1 | Completion interrupt enable |
| cfg_int_half | input | 1 | Half-count interrupt enable |
| cfg_auto_stop | input | 1 | Request-disable at completion enable |
| beat_req | output | 1 | Request for a read/write beat |
| citer | output | IT_W | Current iteration count |
| done | output | 1 | Major loop completion flag |
| link_req | output | 1 | Link request pulse |
| link_ch | output | CH_W | Target channel of the link request |
| int_major | output | 1 | Completion interrupt pulse |
| int_half | output | 1 | Half-count interrupt pulse |
| req_off | output | 1 | Pulse to clear the hardware request enable |
| cfg_err | output | 1 | Configuration error pulse |

## Verification
The assertions assume three things about the inputs. The configuration stays stable from a start until the loop ends. `beat_done` is only a response to a raised `beat_req`. The begin count is not changed in the middle of a major loop. The stimulus respects all three: configuration is drawn from `$urandom` with a fixed seed and changed only between major loops, while the block is idle. Beats are acknowledged only while `beat_req` is high, after a random wait. The directed cases cover a `beat_done` and a `sw_start` given while they must be ignored, since those are the only inputs sent outside their normal window.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_BEAT, ST_STALL} seq_st_t;

  localparam logic [1:0] LK_MINOR = 2'd1;
  localparam logic [1:0] LK_MAJOR = 2'd2;

  localparam logic [1:0] BW_SHORT = 2'd2;
  localparam logic [1:0] BW_LONG  = 2'd3;
endpackage

// File: rtl/dlc_stall_timer.sv
module dlc_stall_timer #(
  parameter int ST_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [ST_W-1:0] load_val,
  output logic            expire
);
  logic [ST_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
    else
      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire = (cnt_q == ST_W'(1));
endmodule

// File: rtl/dlc_beat_seq.sv
module dlc_beat_seq
  import dlc_pkg::*;
#(
  parameter int NB_W        = 10,
  parameter int BEAT_BYTES  = 4,
  parameter int STALL_SHORT = 4,
  parameter int STALL_LONG  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_ok,
  input  logic            beat_done,
  input  logic            restart,
  input  logic [NB_W-1:0] cfg_nbytes,
  input  logic [1:0]      cfg_bwc,
  output logic            beat_req,
  output logic            minor_end,
  output logic            busy
);
  localparam int ST_W = $clog2(STALL_LONG + 1);
  localparam logic [NB_W-1:0] BEAT_V = NB_W'(BEAT_BYTES);

  seq_st_t         st_q, st_d;
  logic [NB_W-1:0] left_q, left_d;
  logic            left_en;
  logic            tmr_load, tmr_expire;
  logic [ST_W-1:0] stall_len;
  logic            last_beat;

  always_comb begin
    case (cfg_bwc)
      BW_SHORT: stall_len = ST_W'(STALL_SHORT);
      BW_LONG:  stall_len = ST_W'(STALL_LONG);
      default:  stall_len = '0;
    endcase
  end

  assign last_beat = (left_q == BEAT_V);
  assign minor_end = (st_q == ST_BEAT) && beat_done && last_beat;

  always_comb begin
    st_d     = st_q;
    left_d   = left_q;
    left_en  = 1'b0;
    tmr_load = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_ok) begin
          st_d    = ST_BEAT;
          left_d  = cfg_nbytes;
          left_en = 1'b1;
        end
      end
      ST_BEAT: begin
        if (beat_done) begin
          if (last_beat) begin
            if (restart) begin
              left_d  = cfg_nbytes;
              left_en = 1'b1;
            end else begin
              st_d = ST_IDLE;
            end
          end else begin
            left_d  = left_q - BEAT_V;
            left_en = 1'b1;
            if (stall_len != '0) begin
              st_d     = ST_STALL;
              tmr_load = 1'b1;
            end
          end
        end
      end
      ST_STALL: begin
        if (tmr_expire) st_d = ST_BEAT;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       left_q <= '0;
    else if (left_en) left_q <= left_d;
  end

  dlc_stall_timer #(.ST_W(ST_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (stall_len),
    .expire   (tmr_expire)
  );

  assign beat_req = (st_q == ST_BEAT);
  assign busy     = (st_q != ST_IDLE);

  // R3
  stall_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_req && beat_done && !last_beat && stall_len != '0) |=> !beat_req);

  // R9
  self_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (minor_end && restart) |=> beat_req);
endmodule

// File: rtl/dlc_iter_unit.sv
module dlc_iter_unit
  import dlc_pkg::*;
#(
  parameter int IT_W = 9,
  parameter int CH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_ok,
  input  logic            minor_end,
  input  logic            done_clr,
  input  logic [IT_W-1:0] cfg_biter,
  input  logic [1:0]      cfg_link_mode,
  input  logic [CH_W-1:0] cfg_link_ch,
  input  logic [CH_W-1:0] cfg_self_ch,
  input  logic            cfg_contlink,
  input  logic            cfg_int_major,
  input  logic            cfg_int_half,
  input  logic            cfg_auto_stop,
  output logic            first,
  output logic            restart,
  output logic [IT_W-1:0] citer,
  output logic            done,
  output logic            link_req,
  output logic [CH_W-1:0] link_ch,
  output logic            int_major,
  output logic            int_half,
  output logic            req_off
);
  logic [IT_W-1:0] citer_q, citer_d, cit_next;
  logic            citer_en;
  logic            first_q, done_q;
  logic            exhaust, self_loop, major_evt, link_fire, half_hit;
  logic            link_q, imaj_q, ihalf_q, roff_q;
  logic [CH_W-1:0] lch_q;

  assign cit_next  = citer_q - 1'b1;
  assign exhaust   = (cit_next == '0);
  assign self_loop = cfg_contlink && (cfg_link_mode == LK_MINOR) &&
                     (cfg_link_ch == cfg_self_ch) && !exhaust;
  assign restart   = minor_end && self_loop;
  assign major_evt = minor_end && exhaust;
  assign link_fire = minor_end && (((cfg_link_mode == LK_MINOR) && !self_loop) ||
                                   ((cfg_link_mode == LK_MAJOR) && exhaust));
  assign half_hit  = minor_end && cfg_int_half && (cfg_biter >= IT_W'(2)) &&
                     (cit_next == (cfg_biter >> 1));

  always_comb begin
    citer_en = 1'b0;
    citer_d  = citer_q;
    if (start_ok && first_q) begin
      citer_en = 1'b1;
      citer_d  = cfg_biter;
    end else if (minor_end) begin
      citer_en = 1'b1;
      citer_d  = exhaust ? cfg_biter : cit_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        citer_q <= '0;
    else if (citer_en) citer_q <= citer_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         first_q <= 1'b1;
    else if (major_evt) first_q <= 1'b1;
    else if (start_ok)  first_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         done_q <= 1'b0;
    else if (major_evt) done_q <= 1'b1;
    else if (done_clr)  done_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q  <= 1'b0;
      imaj_q  <= 1'b0;
      ihalf_q <= 1'b0;
      roff_q  <= 1'b0;
    end else begin
      link_q  <= link_fire;
      imaj_q  <= major_evt && cfg_int_major;
      ihalf_q <= half_hit;
      roff_q  <= major_evt && cfg_auto_stop;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         lch_q <= '0;
    else if (link_fire) lch_q <= cfg_link_ch;
  end

  assign first     = first_q;
  assign citer     = citer_q;
  assign done      = done_q;
  assign link_req  = link_q;
  assign link_ch   = lch_q;
  assign int_major = imaj_q;
  assign int_half  = ihalf_q;
  assign req_off   = roff_q;

  // R2
  citer_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    major_evt |=> (citer_q == $past(cfg_biter)) && done_q);

  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !done_clr) |=> done_q);

  // R5
  major_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    imaj_q |-> (done_q && first_q));

  // R7
  req_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    roff_q |-> (done_q && !$past(roff_q)));
endmodule

// File: rtl/dma_loop_ctrl.sv
module dma_loop_ctrl #(
  parameter int NB_W        = 10,
  parameter int IT_W        = 9,
  parameter int CH_W        = 4,
  parameter int BEAT_BYTES  = 4,
  parameter int STALL_SHORT = 4,
  parameter int STALL_LONG  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hw_req,
  input  logic            sw_start,
  input  logic            beat_done,
  input  logic            done_clr,
  input  logic [NB_W-1:0] cfg_nbytes,
  input  logic [IT_W-1:0] cfg_biter,
  input  logic [1:0]      cfg_bwc,
  input  logic [1:0]      cfg_link_mode,
  input  logic [CH_W-1:0] cfg_link_ch,
  input  logic [CH_W-1:0] cfg_self_ch,
  input  logic            cfg_contlink,
  input  logic            cfg_int_major,
  input  logic            cfg_int_half,
  input  logic            cfg_auto_stop,
  output logic            beat_req,
  output logic [IT_W-1:0] citer,
  output logic            done,
  output logic            link_req,
  output logic [CH_W-1:0] link_ch,
  output logic            int_major,
  output logic            int_half,
  output logic            req_off,
  output logic            cfg_err
);
  localparam logic [NB_W-1:0] ALIGN_MASK = NB_W'(BEAT_BYTES - 1);

  logic busy, first, restart, minor_end;
  logic start_req, cfg_bad, start_ok;
  logic err_q;

  assign start_req = (hw_req || sw_start) && !busy;
  assign cfg_bad   = (cfg_nbytes == '0) || ((cfg_nbytes & ALIGN_MASK) != '0) ||
                     (first && (cfg_biter == '0));
  assign start_ok  = start_req && !cfg_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= start_req && cfg_bad;
  end
  assign cfg_err = err_q;

  dlc_beat_seq #(
    .NB_W(NB_W), .BEAT_BYTES(BEAT_BYTES),
    .STALL_SHORT(STALL_SHORT), .STALL_LONG(STALL_LONG)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_ok   (start_ok),
    .beat_done  (beat_done),
    .restart    (restart),
    .cfg_nbytes (cfg_nbytes),
    .cfg_bwc    (cfg_bwc),
    .beat_req   (beat_req),
    .minor_end  (minor_end),
    .busy       (busy)
  );

  dlc_iter_unit #(.IT_W(IT_W), .CH_W(CH_W)) u_iter (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_ok      (start_ok),
    .minor_end     (minor_end),
    .done_clr      (done_clr),
    .cfg_biter     (cfg_biter),
    .cfg_link_mode (cfg_link_mode),
    .cfg_link_ch   (cfg_link_ch),
    .cfg_self_ch   (cfg_self_ch),
    .cfg_contlink  (cfg_contlink),
    .cfg_int_major (cfg_int_major),
    .cfg_int_half  (cfg_int_half),
    .cfg_auto_stop (cfg_auto_stop),
    .first         (first),
    .restart       (restart),
    .citer         (citer),
    .done          (done),
    .link_req      (link_req),
    .link_ch       (link_ch),
    .int_major     (int_major),
    .int_half      (int_half),
    .req_off       (req_off)
  );

  // R8
  cfg_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !beat_req);

  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_req && !beat_done) |=> beat_req);
endmodule

// File: tb/sim_dma_loop_ctrl.sv
module sim_dma_loop_ctrl;
  localparam int NB_W = 10;
  localparam int IT_W = 9;
  localparam int CH_W = 4;
  localparam int BB   = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic hw_req, sw_start, beat_done, done_clr;
  logic [NB_W-1:0] cfg_nbytes;
  logic [IT_W-1:0] cfg_biter;
  logic [1:0] cfg_bwc, cfg_link_mode;
  logic [CH_W-1:0] cfg_link_ch, cfg_self_ch;
  logic cfg_contlink, cfg_int_major, cfg_int_half, cfg_auto_stop;
  logic beat_req, done, link_req, int_major, int_half, req_off, cfg_err;
  logic [IT_W-1:0] citer;
  logic [CH_W-1:0] link_ch;

  int n_chk = 0;
  int n_fail = 0;
  int m_citer;
  bit m_first, m_done, m_restart, poke_start;

  always #4 clk = ~clk;

  dma_loop_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .sw_start(sw_start),
    .beat_done(beat_done), .done_clr(done_clr), .cfg_nbytes(cfg_nbytes),
    .cfg_biter(cfg_biter), .cfg_bwc(cfg_bwc), .cfg_link_mode(cfg_link_mode),
    .cfg_link_ch(cfg_link_ch), .cfg_self_ch(cfg_self_ch), .cfg_contlink(cfg_contlink),
    .cfg_int_major(cfg_int_major), .cfg_int_half(cfg_int_half),
    .cfg_auto_stop(cfg_auto_stop), .beat_req(beat_req), .citer(citer), .done(done),
    .link_req(link_req), .link_ch(link_ch), .int_major(int_major),
    .int_half(int_half), .req_off(req_off), .cfg_err(cfg_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int stall_len(input logic [1:0] code);
    if (code == 2'd2) return 4;
    if (code == 2'd3) return 8;
    return 0;
  endfunction

  task automatic start_pulse(input bit hw);
    if (hw) hw_req = 1'b1; else sw_start = 1'b1;
    @(negedge clk);
    hw_req = 1'b0;
    sw_start = 1'b0;
  endtask

  task automatic serve_loop();
    int nb = int'(cfg_nbytes) / BB;
    for (int i = 0; i < nb; i++) begin
      int g = 0;
      while (!beat_req && g < 30) begin g++; @(negedge clk); end
      chk("R1 beat_req before beat", int'(beat_req), 1);
      repeat ($urandom_range(0, 2)) @(negedge clk);
      beat_done = 1'b1;
      if (poke_start && i < nb - 1) sw_start = 1'b1;
      @(negedge clk);
      beat_done = 1'b0;
      sw_start = 1'b0;
      if (i < nb - 1) begin
        int cnt = 0;
        while (!beat_req && cnt < 30) begin cnt++; @(negedge clk); end
        chk("R3 stall gap", cnt, stall_len(cfg_bwc));
      end
    end
  endtask

  task automatic finish_minor();
    int nw;
    bit maj, cont, exp_link, half;
    serve_loop();
    nw = m_citer - 1;
    maj = (nw == 0);
    cont = cfg_contlink && cfg_link_mode == 2'd1 && cfg_link_ch == cfg_self_ch && !maj;
    exp_link = (cfg_link_mode == 2'd1 && !cont) || (cfg_link_mode == 2'd2 && maj);
    half = cfg_int_half && cfg_biter >= 2 && nw == int'(cfg_biter) / 2;
    m_citer = maj ? int'(cfg_biter) : nw;
    m_first = maj;
    m_done = m_done || maj;
    m_restart = cont;
    chk("R4 link_req", int'(link_req), int'(exp_link));
    if (exp_link) chk("R4 link_ch", int'(link_ch), int'(cfg_link_ch));
    chk("R5 int_major", int'(int_major), int'(cfg_int_major && maj));
    chk("R6 int_half", int'(int_half), int'(half));
    chk("R7 req_off", int'(req_off), int'(cfg_auto_stop && maj));
    chk("R2 done", int'(done), int'(m_done));
    chk("R2 citer", int'(citer), m_citer);
    chk("R9 R1 beat_req after minor end", int'(beat_req), int'(cont));
  endtask

  task automatic run_request(input bit hw);
    start_pulse(hw);
    chk("R11 start accepted", int'(beat_req), 1);
    if (m_first) begin m_citer = int'(cfg_biter); m_first = 1'b0; end
    do finish_minor(); while (m_restart);
    @(negedge clk);
    chk("R5 pulse one cycle", int'(int_major), 0);
    chk("R4 pulse one cycle", int'(link_req), 0);
  endtask

  task automatic run_major(input bit hw);
    do run_request(hw); while (!m_first);
  endtask

  task automatic clear_done();
    done_clr = 1'b1;
    @(negedge clk);
    done_clr = 1'b0;
    m_done = 1'b0;
    chk("R10 done cleared", int'(done), 0);
  endtask

  task automatic expect_err(input string tag);
    sw_start = 1'b1;
    @(negedge clk);
    sw_start = 1'b0;
    chk({tag, " cfg_err"}, int'(cfg_err), 1);
    chk({tag, " no beat"}, int'(beat_req), 0);
    @(negedge clk);
    chk({tag, " err pulse"}, int'(cfg_err), 0);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog R1 actual=hung expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    rst_n = 1'b0; hw_req = 0; sw_start = 0; beat_done = 0; done_clr = 0;
    cfg_nbytes = 10'd8; cfg_biter = 9'd3; cfg_bwc = 0; cfg_link_mode = 2'd1;
    cfg_link_ch = 4'd5; cfg_self_ch = 4'd2; cfg_contlink = 0;
    cfg_int_major = 1; cfg_int_half = 1; cfg_auto_stop = 1;
    m_citer = 0; m_first = 1; m_done = 0; m_restart = 0; poke_start = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset beat_req", int'(beat_req), 0);
    chk("R2 reset citer", int'(citer), 0);
    chk("R10 reset done", int'(done), 0);
    chk("R8 reset cfg_err", int'(cfg_err), 0);

    // Minor link, half at count 1 of 3, software then hardware start
    run_request(1'b0);
    run_request(1'b1);
    run_request(1'b0);
    clear_done();

    // R1: beat_done while idle is ignored
    beat_done = 1'b1;
    @(negedge clk);
    beat_done = 1'b0;
    chk("R1 idle beat_done", int'(beat_req), 0);
    chk("R1 idle citer", int'(citer), 3);
    chk("R1 idle link", int'(link_req), 0);

    // Stall codes, major link, R11 start while busy
    cfg_nbytes = 10'd16; cfg_biter = 9'd2; cfg_link_mode = 2'd2; cfg_bwc = 2'd2;
    poke_start = 1;
    run_major(1'b0);
    cfg_bwc = 2'd3;
    run_major(1'b1);
    cfg_bwc = 2'd1;
    run_major(1'b0);
    poke_start = 0;

    // R10: clear and set in the same cycle, set wins
    cfg_nbytes = 10'd4; cfg_biter = 9'd1; cfg_bwc = 0;
    start_pulse(1'b0);
    beat_done = 1'b1; done_clr = 1'b1;
    @(negedge clk);
    beat_done = 1'b0; done_clr = 1'b0;
    chk("R10 set wins", int'(done), 1);
    clear_done();

    // R9: continuous self-link runs the whole major loop from one start
    cfg_nbytes = 10'd8; cfg_biter = 9'd4; cfg_link_mode = 2'd1;
    cfg_link_ch = 4'd2; cfg_self_ch = 4'd2; cfg_contlink = 1;
    run_request(1'b0);
    chk("R9 one start completes", int'(m_first), 1);
    // self-link without continuous mode: link pulse, no restart
    cfg_contlink = 0;
    run_major(1'b0);
    clear_done();

    // R8: configuration errors
    cfg_nbytes = 10'd0;  expect_err("R8 zero nbytes");
    cfg_nbytes = 10'd6;  expect_err("R8 unaligned nbytes");
    cfg_nbytes = 10'd8; cfg_biter = 9'd0; expect_err("R8 zero biter");

    // Random major loops
    for (int k = 0; k < 25; k++) begin
      cfg_nbytes    = NB_W'(BB * $urandom_range(1, 6));
      cfg_biter     = IT_W'($urandom_range(1, 6));
      cfg_bwc       = 2'($urandom_range(0, 3));
      cfg_link_mode = 2'($urandom_range(0, 3));
      cfg_link_ch   = 4'($urandom_range(0, 3));
      cfg_self_ch   = 4'($urandom_range(0, 3));
      cfg_contlink  = 1'($urandom_range(0, 1));
      cfg_int_major = 1'($urandom_range(0, 1));
      cfg_int_half  = 1'($urandom_range(0, 1));
      cfg_auto_stop = 1'($urandom_range(0, 1));
      run_major(1'($urandom_range(0, 1)));
      if ($urandom_range(0, 1) == 1) clear_done();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule